// File: doc/BRIEF.md
# Interleaved Host-Managed Memory Window Decoder

This block is one address decoder of a memory expander. Software programs a window into the host physical address space: a 64-bit start and a 64-bit length, each loaded as two 32-bit halves, plus a control word. The control word holds the interleave granularity, the number of interleave ways, and a commit handshake. A host access that lands inside the window is turned into a device physical address. The translation keeps the low granule bits of the window offset. It then drops the way-select bits just above them by shifting every higher bit down by the way count.

Each request gets one registered response, one cycle after it is issued. The response carries the translated address, a hit flag, and a separate flag that is raised when the translated address lies beyond the device capacity. A read that misses the window or exceeds the capacity is answered with an error. A write in the same situation is quietly discarded: its response never carries an error.

Top module: `hdm_window_decoder`

## Requirements
- R1: The window start is {start_hi, start_lo}. start_lo is written with select code 0 and start_hi with select code 1. A request whose address is below the start gives rsp_hit_o = 0.
- R2: The window length is {len_hi, len_lo}. len_lo is written with select code 2 and len_hi with select code 3. With offset = address − start, an offset equal to or above the length gives rsp_hit_o = 0, and an offset of length − 1 still hits.
- R3: The control word uses select code 3'd4. The granularity G sits in bits [3:0] and the way count W in bits [7:4]. On a hit, rsp_dpa_o = (offset mod 2^(8+G)) + ((offset >> (8+G+W)) << (8+G)). On a miss, rsp_dpa_o is 0.
- R4: A control write with bit 9 (commit) set stores the written word, except that bit 9 and bit 11 (error) read back as 0 and bit 10 (committed) reads back as 1. The control word is visible on ctrl_o one cycle after the write.
- R5: A control write with bit 9 clear stores all other bits as written and leaves bit 10 (committed) at its previous value.
- R6: rsp_bound_fail_o is 1 exactly when the request hits and the translated address is strictly greater than DEV_CAP. A translated address equal to DEV_CAP is accepted.
- R7: A read response (rsp_write_o = 0) has rsp_err_o = 1 when it misses or fails the bound check. A write response never has rsp_err_o set.
- R8: rsp_valid_o is 1 in the cycle after a cycle with req_valid_i = 1 and 0 otherwise. rsp_write_o echoes the request direction.
- R9: A request issued in the same cycle as a configuration write is translated with the configuration from before that write.
- R10: After reset, ctrl_o, the window start and the window length are all 0, rsp_valid_o is 0, and every read misses with an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Register select: 0 start_lo, 1 start_hi, 2 len_lo, 3 len_hi, 4 control |
| cfg_wdata_i | input | REG_W | Configuration write data |
| ctrl_o | output | REG_W | Current control word |
| req_valid_i | input | 1 | Host request valid |
| req_write_i | input | 1 | Request is a write |
| req_addr_i | input | 2*REG_W | Host physical address |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_write_o | output | 1 | Echo of the request direction |
| rsp_hit_o | output | 1 | Address inside the window |
| rsp_bound_fail_o | output | 1 | Translated address beyond the device capacity |
| rsp_err_o | output | 1 | Error response for a failed read |
| rsp_dpa_o | output | 2*REG_W | Device physical address |

## Verification
A configuration write and a translation can happen in the same cycle. The register update and the response capture share one clock edge. The bench provokes this by moving the window start, within one cycle, to a value that flips the outcome of a request issued in that same cycle. It expects the response computed from the old start. A second request, issued right after, must see the new start. Random runs also re-program the control word at random points between requests, which covers decode and commit bookkeeping across many granularity and way combinations.

// File: rtl/hdm_pkg.sv
package hdm_pkg;
  localparam int unsigned GRAN_LOG2 = 8;

  typedef enum logic [2:0] {
    SEL_START_LO = 3'd0,
    SEL_START_HI = 3'd1,
    SEL_LEN_LO   = 3'd2,
    SEL_LEN_HI   = 3'd3,
    SEL_CTRL     = 3'd4
  } cfg_sel_e;

  localparam int unsigned CTRL_G_LSB     = 0;
  localparam int unsigned CTRL_W_LSB     = 4;
  localparam int unsigned CTRL_COMMIT    = 9;
  localparam int unsigned CTRL_COMMITTED = 10;
  localparam int unsigned CTRL_ERR       = 11;
endpackage

// File: rtl/hdm_cfg_regs.sv
module hdm_cfg_regs
  import hdm_pkg::*;
#(
  parameter int unsigned REG_W = 32,
  parameter int unsigned G_W   = 4,
  parameter int unsigned W_W   = 4,
  localparam int unsigned AW   = 2 * REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [AW-1:0]    start_o,
  output logic [AW-1:0]    len_o,
  output logic [G_W-1:0]   gran_o,
  output logic [W_W-1:0]   ways_o,
  output logic [REG_W-1:0] ctrl_o
);
  logic [REG_W-1:0] start_q [2];
  logic [REG_W-1:0] len_q   [2];
  logic [REG_W-1:0] ctrl_q, ctrl_d;

  // commit handshake folded into the stored value
  always_comb begin
    ctrl_d = wdata_i;
    if (wdata_i[CTRL_COMMIT]) begin
      ctrl_d[CTRL_COMMIT]    = 1'b0;
      ctrl_d[CTRL_ERR]       = 1'b0;
      ctrl_d[CTRL_COMMITTED] = 1'b1;
    end else begin
      ctrl_d[CTRL_COMMITTED] = ctrl_q[CTRL_COMMITTED];
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        start_q[h] <= '0;
        len_q[h]   <= '0;
      end else if (we_i) begin
        if (sel_i == 3'(h))     start_q[h] <= wdata_i;
        if (sel_i == 3'(h + 2)) len_q[h]   <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        ctrl_q <= '0;
    else if (we_i && sel_i == SEL_CTRL) ctrl_q <= ctrl_d;
  end

  assign start_o = {start_q[1], start_q[0]};
  assign len_o   = {len_q[1], len_q[0]};
  assign gran_o  = ctrl_q[CTRL_G_LSB +: G_W];
  assign ways_o  = ctrl_q[CTRL_W_LSB +: W_W];
  assign ctrl_o  = ctrl_q;
endmodule

// File: rtl/hdm_xlate.sv
module hdm_xlate
  import hdm_pkg::*;
#(
  parameter int unsigned AW  = 64,
  parameter int unsigned G_W = 4,
  parameter int unsigned W_W = 4,
  localparam int unsigned SH_W = $clog2(AW) + 1
) (
  input  logic [AW-1:0]  addr_i,
  input  logic [AW-1:0]  start_i,
  input  logic [AW-1:0]  len_i,
  input  logic [G_W-1:0] gran_i,
  input  logic [W_W-1:0] ways_i,
  output logic           hit_o,
  output logic [AW-1:0]  dpa_o
);
  logic [AW-1:0]   offset;
  logic [SH_W-1:0] keep_sh, cut_sh;
  logic [AW-1:0]   low_mask, high_mask;

  assign offset    = addr_i - start_i;
  assign hit_o     = (addr_i >= start_i) && (offset < len_i);
  assign keep_sh   = SH_W'(GRAN_LOG2) + SH_W'(gran_i);
  assign cut_sh    = keep_sh + SH_W'(ways_i);
  assign low_mask  = ~({AW{1'b1}} << keep_sh);
  assign high_mask = {AW{1'b1}} << cut_sh;
  // way-select bits between keep_sh and cut_sh are squeezed out
  assign dpa_o     = (offset & low_mask) | ((offset & high_mask) >> ways_i);
endmodule

// File: rtl/hdm_rsp_stage.sv
module hdm_rsp_stage #(
  parameter int unsigned AW = 64,
  parameter logic [AW-1:0] CAP = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          write_i,
  input  logic          hit_i,
  input  logic [AW-1:0] dpa_i,
  output logic          valid_o,
  output logic          write_o,
  output logic          hit_o,
  output logic          bound_fail_o,
  output logic          err_o,
  output logic [AW-1:0] dpa_o
);
  logic          bf_d, err_d;
  logic [AW-1:0] dpa_d;

  assign bf_d  = hit_i && (dpa_i > CAP);
  assign dpa_d = hit_i ? dpa_i : '0;
  assign err_d = !write_i && (!hit_i || bf_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      write_o      <= 1'b0;
      hit_o        <= 1'b0;
      bound_fail_o <= 1'b0;
      err_o        <= 1'b0;
      dpa_o        <= '0;
    end else begin
      valid_o      <= valid_i;
      write_o      <= write_i;
      hit_o        <= hit_i;
      bound_fail_o <= bf_d;
      err_o        <= err_d;
      dpa_o        <= dpa_d;
    end
  end
endmodule

// File: rtl/hdm_window_decoder.sv
module hdm_window_decoder #(
  parameter int unsigned REG_W   = 32,
  parameter int unsigned G_W     = 4,
  parameter int unsigned W_W     = 4,
  parameter logic [63:0] DEV_CAP = 64'h0000_0001_0000_0000,
  localparam int unsigned AW     = 2 * REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_sel_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  output logic [REG_W-1:0] ctrl_o,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [AW-1:0]    req_addr_i,
  output logic             rsp_valid_o,
  output logic             rsp_write_o,
  output logic             rsp_hit_o,
  output logic             rsp_bound_fail_o,
  output logic             rsp_err_o,
  output logic [AW-1:0]    rsp_dpa_o
);
  logic [AW-1:0]  start, len, raw_dpa;
  logic [G_W-1:0] gran;
  logic [W_W-1:0] ways;
  logic           raw_hit;

  hdm_cfg_regs #(.REG_W(REG_W), .G_W(G_W), .W_W(W_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .start_o (start),
    .len_o   (len),
    .gran_o  (gran),
    .ways_o  (ways),
    .ctrl_o  (ctrl_o)
  );

  hdm_xlate #(.AW(AW), .G_W(G_W), .W_W(W_W)) u_xlate (
    .addr_i  (req_addr_i),
    .start_i (start),
    .len_i   (len),
    .gran_i  (gran),
    .ways_i  (ways),
    .hit_o   (raw_hit),
    .dpa_o   (raw_dpa)
  );

  hdm_rsp_stage #(.AW(AW), .CAP(AW'(DEV_CAP))) u_rsp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (req_valid_i),
    .write_i      (req_write_i),
    .hit_i        (raw_hit),
    .dpa_i        (raw_dpa),
    .valid_o      (rsp_valid_o),
    .write_o      (rsp_write_o),
    .hit_o        (rsp_hit_o),
    .bound_fail_o (rsp_bound_fail_o),
    .err_o        (rsp_err_o),
    .dpa_o        (rsp_dpa_o)
  );
endmodule

// File: rtl/hdm_window_decoder_chk.sv
module hdm_window_decoder_chk #(
  parameter int unsigned REG_W = 32,
  localparam int unsigned AW   = 2 * REG_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [2:0]       cfg_sel_i,
  input logic [REG_W-1:0] cfg_wdata_i,
  input logic [REG_W-1:0] ctrl_o,
  input logic             req_valid_i,
  input logic             req_write_i,
  input logic             rsp_valid_o,
  input logic             rsp_write_o,
  input logic             rsp_hit_o,
  input logic             rsp_bound_fail_o,
  input logic             rsp_err_o,
  input logic [AW-1:0]    rsp_dpa_o
);
  import hdm_pkg::*;

  logic ctrl_wr;
  assign ctrl_wr = cfg_we_i && (cfg_sel_i == SEL_CTRL);

  assert_rsp_follows_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o && (rsp_write_o == $past(req_write_i)));
  assert_no_rsp_when_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  assert_commit_handshake_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && cfg_wdata_i[CTRL_COMMIT]) |=>
      ctrl_o[CTRL_COMMITTED] && !ctrl_o[CTRL_COMMIT] && !ctrl_o[CTRL_ERR]);
  assert_committed_kept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !cfg_wdata_i[CTRL_COMMIT]) |=>
      ctrl_o[CTRL_COMMITTED] == $past(ctrl_o[CTRL_COMMITTED]));
  assert_bound_needs_hit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_bound_fail_o |-> rsp_hit_o);
  assert_write_never_errs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_write_o) |-> !rsp_err_o);
  assert_read_miss_errs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_write_o && (!rsp_hit_o || rsp_bound_fail_o)) |-> rsp_err_o);
  assert_miss_zero_dpa_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> (rsp_dpa_o == '0));
endmodule

bind hdm_window_decoder hdm_window_decoder_chk #(.REG_W(REG_W)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .cfg_we_i         (cfg_we_i),
  .cfg_sel_i        (cfg_sel_i),
  .cfg_wdata_i      (cfg_wdata_i),
  .ctrl_o           (ctrl_o),
  .req_valid_i      (req_valid_i),
  .req_write_i      (req_write_i),
  .rsp_valid_o      (rsp_valid_o),
  .rsp_write_o      (rsp_write_o),
  .rsp_hit_o        (rsp_hit_o),
  .rsp_bound_fail_o (rsp_bound_fail_o),
  .rsp_err_o        (rsp_err_o),
  .rsp_dpa_o        (rsp_dpa_o)
);

// File: tb/hdm_window_decoder_test.sv
module hdm_window_decoder_test;
  localparam logic [63:0] CAP = 64'h0000_0001_0000_0000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_sel_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] ctrl_o;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [63:0] req_addr_i = '0;
  logic        rsp_valid_o, rsp_write_o, rsp_hit_o, rsp_bound_fail_o, rsp_err_o;
  logic [63:0] rsp_dpa_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [63:0] m_start = '0, m_len = '0;
  logic [31:0] m_ctrl = '0;

  always #4 clk = ~clk;

  hdm_window_decoder #(.DEV_CAP(CAP)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
    .cfg_wdata_i(cfg_wdata_i), .ctrl_o(ctrl_o), .req_valid_i(req_valid_i),
    .req_write_i(req_write_i), .req_addr_i(req_addr_i), .rsp_valid_o(rsp_valid_o),
    .rsp_write_o(rsp_write_o), .rsp_hit_o(rsp_hit_o),
    .rsp_bound_fail_o(rsp_bound_fail_o), .rsp_err_o(rsp_err_o), .rsp_dpa_o(rsp_dpa_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl_rule(input logic [31:0] old_c, input logic [31:0] w);
    logic [31:0] c = w;
    if (w[9]) begin c[9] = 0; c[11] = 0; c[10] = 1; end
    else c[10] = old_c[10];
    return c;
  endfunction

  function automatic void model_wr(input logic [2:0] sel, input logic [31:0] d);
    case (sel)
      3'd0: m_start[31:0]  = d;
      3'd1: m_start[63:32] = d;
      3'd2: m_len[31:0]    = d;
      3'd3: m_len[63:32]   = d;
      3'd4: m_ctrl = ctrl_rule(m_ctrl, d);
      default: ;
    endcase
  endfunction

  typedef struct { logic hit; logic [63:0] dpa; logic bf; logic err; } exp_t;

  function automatic exp_t expect_rsp(input logic [63:0] a, input logic wr);
    exp_t e;
    logic [63:0] off = a - m_start;
    int g = 8 + int'(m_ctrl[3:0]);
    int w = int'(m_ctrl[7:4]);
    logic [63:0] low = off & ((64'd1 << g) - 64'd1);
    logic [63:0] up  = (off >> (g + w)) << g;
    e.hit = (a >= m_start) && (off < m_len);
    e.dpa = e.hit ? (low | up) : 64'd0;
    e.bf  = e.hit && (e.dpa > CAP);
    e.err = !wr && (!e.hit || e.bf);
    return e;
  endfunction

  task automatic cfg_wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we_i = 1; cfg_sel_i = sel; cfg_wdata_i = d;
    model_wr(sel, d);
    @(negedge clk);
    cfg_we_i = 0;
  endtask

  task automatic set_window(input logic [63:0] s, input logic [63:0] l, input logic [31:0] c);
    cfg_wr(3'd0, s[31:0]); cfg_wr(3'd1, s[63:32]);
    cfg_wr(3'd2, l[31:0]); cfg_wr(3'd3, l[63:32]);
    cfg_wr(3'd4, c);
  endtask

  task automatic check_rsp(input string tag, input exp_t e, input logic wr);
    chk({tag, " valid R8"}, 64'(rsp_valid_o), 64'd1);
    chk({tag, " write R8"}, 64'(rsp_write_o), 64'(wr));
    chk({tag, " hit R1 R2"}, 64'(rsp_hit_o), 64'(e.hit));
    chk({tag, " dpa R3"}, rsp_dpa_o, e.dpa);
    chk({tag, " bound R6"}, 64'(rsp_bound_fail_o), 64'(e.bf));
    chk({tag, " err R7"}, 64'(rsp_err_o), 64'(e.err));
  endtask

  task automatic req(input string tag, input logic [63:0] a, input logic wr);
    exp_t e;
    @(negedge clk);
    req_valid_i = 1; req_write_i = wr; req_addr_i = a;
    e = expect_rsp(a, wr);
    @(negedge clk);
    req_valid_i = 0;
    check_rsp(tag, e, wr);
  endtask

  initial begin
    logic [63:0] base;
    exp_t e;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("reset ctrl R10", 64'(ctrl_o), 64'd0);
    chk("reset valid R10", 64'(rsp_valid_o), 64'd0);
    rst_ni = 1;
    req("reset read R10", 64'd0, 1'b0);
    @(negedge clk);
    chk("idle valid R8", 64'(rsp_valid_o), 64'd0);

    // R5: non-commit write leaves committed at 0
    cfg_wr(3'd4, 32'h0000_0C21);
    chk("no-commit ctrl R5", 64'(ctrl_o), 64'(m_ctrl));
    chk("no-commit bit10 R5", 64'(ctrl_o[10]), 64'd0);

    base = 64'h0000_0001_0000_0000;
    set_window(base, 64'h0000_0000_4000_0000, 32'h0000_0A00);
    chk("commit ctrl R4", 64'(ctrl_o), 64'h0000_0400);

    req("below start R1", base - 1, 1'b0);
    req("at start R1", base, 1'b0);
    req("last byte R2", base + 64'h3FFF_FFFF, 1'b0);
    req("past end R2", base + 64'h4000_0000, 1'b0);
    req("past end write R7", base + 64'h4000_0000, 1'b1);

    // R5: committed held, fields updated; G=2 W=1
    cfg_wr(3'd4, 32'h0000_0812);
    chk("hold committed R5", 64'(ctrl_o), 64'h0000_0C12);
    req("interleave R3", base + 64'h0012_3456, 1'b0);
    req("interleave hi R3", base + 64'h3ABC_DEF7, 1'b1);

    // R6 bound: length beyond capacity, no interleave
    set_window(base, 64'h0000_0002_0000_0000, 32'h0000_0200);
    req("dpa at cap R6", base + CAP, 1'b0);
    req("dpa over cap R6", base + CAP + 1, 1'b0);
    req("dpa over cap write R7", base + CAP + 1, 1'b1);

    // R9: concurrent start move and request use old start
    @(negedge clk);
    cfg_we_i = 1; cfg_sel_i = 3'd1; cfg_wdata_i = 32'h0000_0008;
    req_valid_i = 1; req_write_i = 0; req_addr_i = base + 64'h10;
    e = expect_rsp(base + 64'h10, 1'b0);
    model_wr(3'd1, 32'h0000_0008);
    @(negedge clk);
    cfg_we_i = 0; req_valid_i = 0;
    check_rsp("concurrent R9", e, 1'b0);
    req("after move R9", base + 64'h10, 1'b0);

    // random vectors
    for (int v = 0; v < 400; v++) begin
      if (v % 25 == 0) begin
        logic [63:0] s = {32'($urandom_range(0, 15)), $urandom};
        logic [63:0] l = {32'($urandom_range(0, 7)), $urandom};
        logic [31:0] c = {20'd0, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                          1'($urandom_range(0, 1)), 1'b0,
                          4'($urandom_range(0, 7)), 4'($urandom_range(0, 7))};
        set_window(s, l, c);
        chk("rand ctrl R4 R5", 64'(ctrl_o), 64'(m_ctrl));
      end
      req("random R3", m_start - 64'h1000 + {32'($urandom_range(0, 8)), $urandom},
          1'($urandom_range(0, 1)));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule